// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Codec for 24-bit Configuration Words

This block guards 24-bit configuration words kept in a non-volatile array. On the write side it adds six check bits to the data and hands back the 30-bit word to be stored. Five of the check bits are Hamming parities and the sixth is an overall parity, so the code corrects one flipped bit and detects two.

On the read side a 30-bit stored word is presented with a valid strobe. One clock later the block returns a 30-bit readback word. It holds the corrected data, a two-bit status code and four zero bits. A read that cannot be corrected also sets a sticky fault output. Elsewhere in the chip this output forces the analog output driver into high impedance, so the device stops following its input. Correction can be switched off with an enable input, and it is active straight out of reset.

Top module: `ecc_word_codec`

## Requirements
- R1: The write path is combinational: `wr_word_o[23:0]` equals `wr_data_i`, and check bit Cj sits at `wr_word_o[24+j]` for j = 0..5, with C5 in bit 29.
- R2: Code layout: data bit i occupies the i-th position, counting from 3 upward, that is not a power of two (bit 0→3, bit 1→5, bit 2→6, bit 3→7, bit 4→9, ... bit 23→29). For j = 0..4, Cj is the XOR of the data bits whose position has bit j set. C5 is the XOR of all 29 other stored bits, so a stored word has even parity.
- R3: A clean read returns status 00 in readback bits 25:24, the unchanged data in bits 23:0, and zero in bits 29:26.
- R4: A read with exactly one flipped data bit returns the original data with status 01.
- R5: A read with exactly one flipped check bit (any of C0..C5) returns the stored data unchanged with status 01.
- R6: A read with two flipped bits anywhere in the 30 returns status 10, with readback bits 23:0 equal to the received bits 23:0 uncorrected. Status 11 is never produced.
- R7: `rd_valid_o` is high in exactly the cycle after each cycle in which `rd_valid_i` is high, and `rd_word_o` carries that read's result in the same cycle.
- R8: A read with ECC active and status 10 sets `fault_o`, visible in the same cycle as its readback word. Reads with status 00 or 01 do not set it.
- R9: Once set, `fault_o` stays high through later clean reads and drops only on reset.
- R10: With ECC off, a read returns its received bits 23:0 raw with status 00 and never sets `fault_o`. A change of `ecc_en` applies to reads presented one clock after the change.
- R11: ECC is active for a read presented in the first cycle after reset, whatever the level of `ecc_en`.
- R12: During reset, `rd_valid_o`, `rd_word_o` and `fault_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ecc_en | input | 1 | Enables checking and correction; applies one clock later |
| wr_data_i | input | 24 | Data word to encode |
| wr_word_o | output | 30 | Encoded word for storage: check bits 29:24, data 23:0 |
| rd_valid_i | input | 1 | Marks a stored word on `rd_word_i` |
| rd_word_i | input | 30 | Stored word read back from the array |
| rd_valid_o | output | 1 | Marks a readback result on `rd_word_o` |
| rd_word_o | output | 30 | Zero in 29:26, status in 25:24, data in 23:0 |
| fault_o | output | 1 | Sticky uncorrectable-read fault; commands the output driver off |

## Verification
- **Encoder:** the encoded word is due in the same cycle as its data. The bench drives data on a falling edge and samples one time unit later.
- **Readback and fault:** the readback word and any fault update on the first rising edge after a read is presented. Both are sampled on the falling edge that follows, and the valid strobe is checked low one edge later.
- **Enable changes:** a change to `ecc_en` is given one full clock before the next read.
- **Reset:** the check that ECC is active out of reset presents its read on the same falling edge that releases reset. That read is therefore decoded on the first active edge.

// File: rtl/ecc_codec_pkg.sv
// Package: ecc_codec_pkg
// Shared sizes, the readback status code and the constant functions that
// place data bits into Hamming codeword positions. Assumes positions start
// at 1 and that the five Hamming parities sit at the power-of-two positions.
package ecc_codec_pkg;

    localparam int unsigned DATA_W = 24;
    localparam int unsigned HAM_W  = 5;
    localparam int unsigned CHK_W  = HAM_W + 1;
    localparam int unsigned WORD_W = DATA_W + CHK_W;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_FATAL = 2'b10
    } ecc_status_e;

    // True when v is a nonzero power of two (a parity position)
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    // Codeword position of data bit idx: the idx-th non-power-of-two from 3
    function automatic int unsigned code_pos(input int unsigned idx);
        int unsigned seen;
        int unsigned res;
        seen = 0;
        res  = 0;
        for (int unsigned p = 3; p < 256; p++) begin
            if (!is_pow2(p) && (res == 0)) begin
                if (seen == idx) res = p;
                seen++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/ecc_parity_tree.sv
// Module: ecc_parity_tree
// Computes the Hamming parities of a data word. Parity j is the XOR of every
// data bit whose codeword position has bit j set. Purely combinational.
// Assumes HAM_W parities are enough to cover DATA_W data positions.
module ecc_parity_tree
    import ecc_codec_pkg::*;
#(
    parameter int unsigned D_W = 24,
    parameter int unsigned H_W = 5
) (
    input  logic [D_W-1:0] data_i,
    output logic [H_W-1:0] par_o
);

    logic [H_W-1:0][D_W-1:0] term;

    for (genvar j = 0; j < H_W; j++) begin : g_par
        for (genvar i = 0; i < D_W; i++) begin : g_bit
            localparam bit HIT = ((code_pos(i) >> j) & 1) != 0;
            // Select data bit i into parity j when its position covers j
            assign term[j][i] = HIT ? data_i[i] : 1'b0;
        end
        // Reduce the selected bits to one parity
        assign par_o[j] = ^term[j];
    end

endmodule

// File: rtl/ecc_encoder.sv
// Module: ecc_encoder
// Forms the stored word {overall parity, Hamming parities, data}. The overall
// parity makes the whole stored word even. Purely combinational.
module ecc_encoder
    import ecc_codec_pkg::*;
#(
    parameter int unsigned D_W = 24,
    parameter int unsigned H_W = 5,
    localparam int unsigned W_W = D_W + H_W + 1
) (
    input  logic [D_W-1:0] data_i,
    output logic [W_W-1:0] word_o
);

    logic [H_W-1:0] ham;
    logic           ovr;

    ecc_parity_tree #(.D_W(D_W), .H_W(H_W)) u_tree (
        .data_i (data_i),
        .par_o  (ham)
    );

    // Overall parity over data and Hamming bits
    assign ovr    = ^{ham, data_i};
    assign word_o = {ovr, ham, data_i};

    // Check that every stored word leaves with even parity
    always_comb begin
        if (!$isunknown(data_i)) begin
            AST_ENC_EVEN: assert (^word_o == 1'b0); // R2
        end
    end

endmodule

// File: rtl/ecc_decoder.sv
// Module: ecc_decoder
// Classifies a stored word as clean, single-error (corrected) or
// uncorrectable, and flips the one data bit the syndrome points at.
// An uncorrectable word passes its data bits through raw. Combinational.
module ecc_decoder
    import ecc_codec_pkg::*;
#(
    parameter int unsigned D_W = 24,
    parameter int unsigned H_W = 5,
    localparam int unsigned W_W = D_W + H_W + 1,
    localparam int unsigned CODE_MAX = D_W + H_W
) (
    input  logic [W_W-1:0] word_i,
    output logic [D_W-1:0] data_o,
    output ecc_status_e    status_o
);

    logic [D_W-1:0] data_rx;
    logic [H_W-1:0] ham_rx;
    logic [H_W-1:0] ham_calc;
    logic [H_W-1:0] syn;
    logic           ovr_err;
    logic           syn_nz;
    logic           syn_in_range;
    logic           is_clean;
    logic           is_fixed;
    logic           is_fatal;
    logic [D_W-1:0] flip;

    assign data_rx = word_i[D_W-1:0];
    assign ham_rx  = word_i[D_W +: H_W];

    ecc_parity_tree #(.D_W(D_W), .H_W(H_W)) u_tree (
        .data_i (data_rx),
        .par_o  (ham_calc)
    );

    // Syndrome and overall parity of the received word
    assign syn          = ham_rx ^ ham_calc;
    assign ovr_err      = ^word_i;
    assign syn_nz       = |syn;
    assign syn_in_range = 32'(syn) <= CODE_MAX;

    // Classify: odd parity with a reachable syndrome is one flip
    always_comb begin
        is_clean = !syn_nz && !ovr_err;
        is_fixed = ovr_err && syn_in_range;
        is_fatal = !is_clean && !is_fixed;
    end

    for (genvar i = 0; i < D_W; i++) begin : g_fix
        localparam int unsigned POS = code_pos(i);
        // Flip data bit i when the syndrome names its position
        assign flip[i] = is_fixed && (syn == H_W'(POS));
    end

    assign data_o = data_rx ^ flip;

    // Encode the classification into the status code
    always_comb begin
        if (is_fatal)      status_o = ST_FATAL;
        else if (is_fixed) status_o = ST_FIXED;
        else               status_o = ST_CLEAN;
    end

    // Exactly one class, and at most one corrected bit
    always_comb begin
        if (!$isunknown(word_i)) begin
            AST_ONE_CLASS: assert ($onehot({is_clean, is_fixed, is_fatal})); // R6
            AST_ONE_FLIP: assert ($onehot0(flip)); // R4
        end
    end

endmodule

// File: rtl/ecc_read_stage.sv
// Module: ecc_read_stage
// Registers the readback word with one cycle of latency, applies the ECC
// enable (captured one clock ahead, forced on by reset) and holds the
// sticky uncorrectable-read fault. Assumes a synchronous active-low reset.
module ecc_read_stage
    import ecc_codec_pkg::*;
#(
    parameter int unsigned D_W = 24,
    parameter int unsigned W_W = 30,
    localparam int unsigned PAD_W = W_W - D_W - 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ecc_en_i,
    input  logic           valid_i,
    input  logic [D_W-1:0] raw_data_i,
    input  logic [D_W-1:0] dec_data_i,
    input  ecc_status_e    dec_status_i,
    output logic           valid_o,
    output logic [W_W-1:0] word_o,
    output logic           fault_o
);

    logic           ecc_on_q;
    logic           valid_q;
    logic [W_W-1:0] word_q;
    logic           fault_q;
    logic [1:0]     st_sel;
    logic [D_W-1:0] data_sel;

    // Capture the enable; reset forces correction on
    always_ff @(posedge clk) begin
        if (!rst_n) ecc_on_q <= 1'b1;
        else        ecc_on_q <= ecc_en_i;
    end

    // Choose corrected or raw result for this read
    always_comb begin
        st_sel   = ecc_on_q ? dec_status_i : ST_CLEAN;
        data_sel = ecc_on_q ? dec_data_i   : raw_data_i;
    end

    // Delay the read strobe by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_i;
    end

    // Load the readback word on each read
    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (valid_i) word_q <= {{PAD_W{1'b0}}, st_sel, data_sel};
    end

    // Latch the fault on an uncorrectable read with ECC active
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_q <= 1'b0;
        else if (valid_i && ecc_on_q && (dec_status_i == ST_FATAL))
            fault_q <= 1'b1;
    end

    assign valid_o = valid_q;
    assign word_o  = word_q;
    assign fault_o = fault_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o); // R7
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o); // R7
    AST_NO_CODE11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (word_o[D_W+1:D_W] != 2'b11)); // R6
    AST_FAULT_WITH_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> (valid_o && (word_o[D_W+1:D_W] == 2'b10))); // R8
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o); // R9
    AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !ecc_on_q) |=> (word_o[D_W+1:D_W] == 2'b00)); // R10

endmodule

// File: rtl/ecc_word_codec.sv
// Module: ecc_word_codec
// Top of the configuration-word ECC codec. A combinational encoder feeds the
// array; a combinational decoder plus a registered read stage returns the
// readback word and the sticky fault one clock after each read.
module ecc_word_codec
    import ecc_codec_pkg::*;
#(
    parameter int unsigned DATA_BITS = 24,
    parameter int unsigned HAM_BITS  = 5,
    localparam int unsigned WORD_BITS = DATA_BITS + HAM_BITS + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ecc_en,
    input  logic [DATA_BITS-1:0] wr_data_i,
    output logic [WORD_BITS-1:0] wr_word_o,
    input  logic                 rd_valid_i,
    input  logic [WORD_BITS-1:0] rd_word_i,
    output logic                 rd_valid_o,
    output logic [WORD_BITS-1:0] rd_word_o,
    output logic                 fault_o
);

    logic [DATA_BITS-1:0] dec_data;
    ecc_status_e          dec_status;

    ecc_encoder #(.D_W(DATA_BITS), .H_W(HAM_BITS)) u_enc (
        .data_i (wr_data_i),
        .word_o (wr_word_o)
    );

    ecc_decoder #(.D_W(DATA_BITS), .H_W(HAM_BITS)) u_dec (
        .word_i   (rd_word_i),
        .data_o   (dec_data),
        .status_o (dec_status)
    );

    ecc_read_stage #(.D_W(DATA_BITS), .W_W(WORD_BITS)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .ecc_en_i     (ecc_en),
        .valid_i      (rd_valid_i),
        .raw_data_i   (rd_word_i[DATA_BITS-1:0]),
        .dec_data_i   (dec_data),
        .dec_status_i (dec_status),
        .valid_o      (rd_valid_o),
        .word_o       (rd_word_o),
        .fault_o      (fault_o)
    );

endmodule

// File: tb/ecc_word_codec_tb_top.sv
module ecc_word_codec_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ecc_en;
    logic [23:0] wr_data_i;
    logic [29:0] wr_word_o;
    logic        rd_valid_i;
    logic [29:0] rd_word_i;
    logic        rd_valid_o;
    logic [29:0] rd_word_o;
    logic        fault_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    ecc_word_codec dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ecc_en     (ecc_en),
        .wr_data_i  (wr_data_i),
        .wr_word_o  (wr_word_o),
        .rd_valid_i (rd_valid_i),
        .rd_word_i  (rd_word_i),
        .rd_valid_o (rd_valid_o),
        .rd_word_o  (rd_word_o),
        .fault_o    (fault_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference encoding built from the position rule of R2
    function automatic logic [29:0] ref_encode(input logic [23:0] d);
        logic [31:0] cw;
        logic [4:0]  c;
        int          k;
        cw = '0;
        k  = 0;
        for (int p = 1; p < 30; p++)
            if ((p & (p - 1)) != 0) begin cw[p] = d[k]; k++; end
        for (int j = 0; j < 5; j++) begin
            c[j] = 1'b0;
            for (int p = 1; p < 30; p++)
                if (((p >> j) & 1) == 1) c[j] = c[j] ^ cw[p];
        end
        return {^{c, d}, c, d};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one read; returns on the falling edge where the result is due
    task automatic do_read(input logic [29:0] w);
        @(negedge clk);
        rd_valid_i = 1'b1;
        rd_word_i  = w;
        @(negedge clk);
        rd_valid_i = 1'b0;
    endtask

    task automatic check_read(input logic [29:0] w, input logic [23:0] exp_d,
                              input logic [1:0] exp_st, input string req);
        logic [29:0] exp_w;
        exp_w = {4'b0000, exp_st, exp_d};
        do_read(w);
        check(rd_valid_o == 1'b1, {req, " valid"}, 32'(rd_valid_o), 32'd1);
        check(rd_word_o == exp_w, req, 32'(rd_word_o), 32'(exp_w));
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [23:0] vals [0:33];
        logic [31:0] lcg;
        logic [29:0] enc;
        logic [29:0] bad;

        rst_n      = 1'b0;
        ecc_en     = 1'b1;
        wr_data_i  = '0;
        rd_valid_i = 1'b0;
        rd_word_i  = '0;

        // R12: reset state
        repeat (3) @(negedge clk);
        check(rd_valid_o == 1'b0, "R12 valid", 32'(rd_valid_o), 0);
        check(rd_word_o == '0, "R12 word", 32'(rd_word_o), 0);
        check(fault_o == 1'b0, "R12 fault", 32'(fault_o), 0);
        rst_n = 1'b1;

        // Data set: zero, all ones, walking ones, pseudo-random
        vals[0] = 24'h000000;
        vals[1] = 24'hFFFFFF;
        for (int i = 0; i < 24; i++) vals[2+i] = 24'h1 << i;
        lcg = 32'h1234_5678;
        for (int i = 26; i < 34; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            vals[i] = lcg[31:8];
        end

        // R1, R2: encoder sweep
        for (int v = 0; v < 34; v++) begin
            @(negedge clk);
            wr_data_i = vals[v];
            #1;
            enc = ref_encode(vals[v]);
            check(wr_word_o[23:0] == vals[v], "R1 data field",
                  32'(wr_word_o[23:0]), 32'(vals[v]));
            check(wr_word_o == enc, "R2 check bits", 32'(wr_word_o), 32'(enc));
        end

        // R3: clean reads
        for (int v = 0; v < 34; v++)
            check_read(ref_encode(vals[v]), vals[v], 2'b00, "R3 clean");

        // R4, R5: every single flip of every stored bit
        for (int v = 0; v < 34; v++) begin
            enc = ref_encode(vals[v]);
            for (int b = 0; b < 30; b++) begin
                bad = enc ^ (30'h1 << b);
                if (b < 24) check_read(bad, vals[v], 2'b01, "R4 data flip");
                else        check_read(bad, vals[v], 2'b01, "R5 check flip");
            end
        end
        check(fault_o == 1'b0, "R8 no fault on correctable", 32'(fault_o), 0);

        // R7: strobe drops one cycle after a lone read
        check_read(ref_encode(vals[5]), vals[5], 2'b00, "R7 read");
        @(negedge clk);
        check(rd_valid_o == 1'b0, "R7 valid drop", 32'(rd_valid_o), 0);

        // R10: ECC off -> raw data, status 00, no fault
        @(negedge clk);
        ecc_en = 1'b0;
        enc = ref_encode(vals[30]);
        bad = enc ^ 30'h1 ^ 30'h0000_0100;
        check_read(bad, bad[23:0], 2'b00, "R10 bypass double");
        bad = enc ^ 30'h0000_0020;
        check_read(bad, bad[23:0], 2'b00, "R10 bypass single");
        check(fault_o == 1'b0, "R10 no fault", 32'(fault_o), 0);

        // R6, R8: double flip with ECC on sets the fault
        @(negedge clk);
        ecc_en = 1'b1;
        bad = enc ^ 30'h0000_0003;
        check_read(bad, bad[23:0], 2'b10, "R6 double");
        check(fault_o == 1'b1, "R8 fault set", 32'(fault_o), 1);

        // R9: clean read leaves fault set
        check_read(enc, vals[30], 2'b00, "R9 clean after fault");
        check(fault_o == 1'b1, "R9 sticky", 32'(fault_o), 1);

        // R6: all double flips of two words
        for (int v = 0; v < 2; v++) begin
            enc = ref_encode(vals[v == 0 ? 27 : 1]);
            for (int a = 0; a < 30; a++)
                for (int b = a + 1; b < 30; b++) begin
                    bad = enc ^ (30'h1 << a) ^ (30'h1 << b);
                    check_read(bad, bad[23:0], 2'b10, "R6 double sweep");
                end
        end

        // R9, R11: reset clears fault; first read after reset is corrected
        @(negedge clk);
        rst_n  = 1'b0;
        ecc_en = 1'b0;
        repeat (2) @(negedge clk);
        check(fault_o == 1'b0, "R9 reset clears", 32'(fault_o), 0);
        enc = ref_encode(vals[31]);
        bad = enc ^ 30'h0000_4000;
        rst_n      = 1'b1;
        rd_valid_i = 1'b1;
        rd_word_i  = bad;
        @(negedge clk);
        rd_valid_i = 1'b0;
        check(rd_word_o == {4'b0, 2'b01, vals[31]}, "R11 on from reset",
              32'(rd_word_o), 32'({4'b0, 2'b01, vals[31]}));
        check_read(bad, bad[23:0], 2'b00, "R10 off after capture");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule